// File: doc/BRIEF.md
# Host-to-Slave Word Stream Bridge

The bridge lets a 16-bit host stream data words into a slave-side memory through a small DMA channel. The host sets an expected word length and a start bit, then pushes words one at a time into a short FIFO. The slave side holds the DMA channel settings: a destination byte address, a word count, a two-bit channel mode and a global enable.

Buffered words are drained to the slave write port in groups of four. A group leaves only when the channel mode and the global enable both allow it. Each word moved writes 16 bits and advances the destination by two bytes. It also lowers both the host length and the DMA count. When the host length runs out, the start bit drops. When the DMA count runs out, the channel's end flag rises.

A transfer in progress shows on `busy`. Register writes from either side are dropped while `busy` is high.

Top module: `dreq_bridge`

## Requirements
- R1: After reset, start, rv, full, busy and `wr_valid` are 0, and the length, destination, count, mode and enable registers are 0.
- R2: A host write with `host_sel`=1 loads the length register with the written value, with bits [1:0] forced to zero.
- R3: A host write with `host_sel`=2 (FIFO data) is discarded while the start bit is 0: occupancy does not grow and the word is never sent.
- R4: A FIFO word is accepted only while occupancy is below 4. `fifo_full` rises when occupancy reaches 4, and further FIFO writes are discarded.
- R5: A burst begins one cycle after a FIFO write leaves occupancy at a nonzero multiple of 4, and only if the channel mode equals 2'b01 and the enable bit is 1. Otherwise the words stay buffered.
- R6: Each word moved appears on the slave port with `wr_addr` equal to the destination register. After its handshake, the destination is 2 higher, the count is 1 lower, and the length is 1 lower unless it is already 0. Words leave in arrival order.
- R7: At the end of a burst, the start bit is cleared if the length is 0. A burst stops early once the count reaches 0, and then mode bit 1 (the end flag) is set.
- R8: At the end of every burst, occupancy returns to 0 and `fifo_full` is cleared. Buffered words that were not sent are discarded.
- R9: A host write with `host_sel`=0 sets start from bit 0 and rv from bit 1, and leaves `fifo_full` and the buffered words untouched.
- R10: A slave-side write to the mode (`cfg_sel`=2, bits [1:0]) or to the enable (`cfg_sel`=3, bit 0) starts a burst at once if 4 words are already buffered and the new settings allow it.
- R11: A count write (`cfg_sel`=1) keeps only bits [23:0]. A write with `cfg_sel`=0 loads the destination.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R13: Host and slave-side register writes made while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register: 0 control, 1 length, 2 FIFO data |
| host_wdata | input | 16 | Host write data |
| cfg_wr | input | 1 | Slave-side channel register write strobe |
| cfg_sel | input | 2 | 0 destination, 1 count, 2 mode, 3 enable |
| cfg_wdata | input | 32 | Channel write data |
| wr_ready | input | 1 | Slave port accepts the current word |
| busy | output | 1 | Burst pending or running; writes are dropped |
| host_start | output | 1 | Host start bit |
| host_rv | output | 1 | Host rv bit |
| fifo_full | output | 1 | FIFO holds 4 words |
| host_len | output | 16 | Remaining host length in words |
| dma_dst | output | 32 | Destination byte address |
| dma_cnt | output | 24 | Remaining DMA word count |
| chan_mode | output | 2 | Channel mode; bit 1 is the end flag |
| dma_master | output | 1 | Global DMA enable |
| wr_valid | output | 1 | Slave write request |
| wr_addr | output | 32 | Slave write byte address |
| wr_data | output | 16 | Slave write data |

## Verification
The bench fills the FIFO while the channel is disabled and then enables it. A design that did not re-check on a settings write would strand those four words. It pushes a fifth word into a full FIFO and writes the control register while full, which shows whether an overflow is swallowed and whether the full flag survives. It runs the count out in the middle of a burst: a design that ignored the count would write past the end, and one that forgot the end flag would keep bursting. It also holds `wr_ready` low at random and writes during `busy`, to catch data that slips while stalled and registers that change while a burst owns them.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic {ST_IDLE, ST_MOVE} burst_st_e;
  localparam logic [1:0] H_CTRL = 2'd0;
  localparam logic [1:0] H_LEN  = 2'd1;
  localparam logic [1:0] H_DATA = 2'd2;
  localparam logic [1:0] C_DST  = 2'd0;
  localparam logic [1:0] C_CNT  = 2'd1;
  localparam logic [1:0] C_MODE = 2'd2;
  localparam logic [1:0] C_EN   = 2'd3;
  localparam logic [1:0] MODE_RUN = 2'b01;
endpackage

// File: rtl/dreq_fifo_mem.sv
module dreq_fifo_mem #(
  parameter int DW = 16,
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dreq_host_regs.sv
module dreq_host_regs #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [15:0]   wdata,
  input  logic          step,
  input  logic          finish,
  output logic          start,
  output logic          rv,
  output logic [LW-1:0] len
);
  import dreq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      rv    <= 1'b0;
      len   <= '0;
    end else begin
      if (we && sel == H_CTRL) begin
        start <= wdata[0];
        rv    <= wdata[1];
      end else if (finish && len == '0) begin
        start <= 1'b0;
      end
      if (we && sel == H_LEN) len <= {wdata[LW-1:2], 2'b00};
      else if (step && len != '0) len <= len - 1'b1;
    end
  end

  a_r7_start_off: assert property (@(posedge clk) disable iff (rst)
    (finish && len == '0 && !we) |=> !start);
endmodule

// File: rtl/dreq_dma_chan.sv
module dreq_dma_chan #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          step,
  input  logic          set_end,
  output logic          ctl_we,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic [1:0]    mode,
  output logic          master
);
  import dreq_pkg::*;

  assign ctl_we = we && (sel == C_MODE || sel == C_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      dst    <= '0;
      cnt    <= '0;
      mode   <= '0;
      master <= 1'b0;
    end else if (we) begin
      case (sel)
        C_DST:   dst    <= wdata[AW-1:0];
        C_CNT:   cnt    <= wdata[CW-1:0];
        C_MODE:  mode   <= wdata[1:0];
        default: master <= wdata[0];
      endcase
    end else begin
      if (step) begin
        dst <= dst + AW'(2);
        cnt <= cnt - 1'b1;
      end
      if (set_end) mode[1] <= 1'b1;
    end
  end

  a_r6_word_step: assert property (@(posedge clk) disable iff (rst)
    step |=> (dst == $past(dst) + AW'(2)) && (cnt == $past(cnt) - 1'b1));
  a_r7_end_flag: assert property (@(posedge clk) disable iff (rst)
    set_end |=> mode[1]);
endmodule

// File: rtl/dreq_bridge.sv
module dreq_bridge #(
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int BURST = 4,
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [1:0]    host_sel,
  input  logic [15:0]   host_wdata,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          wr_ready,
  output logic          busy,
  output logic          host_start,
  output logic          host_rv,
  output logic          fifo_full,
  output logic [LW-1:0] host_len,
  output logic [AW-1:0] dma_dst,
  output logic [CW-1:0] dma_cnt,
  output logic [1:0]    chan_mode,
  output logic          dma_master,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  import dreq_pkg::*;

  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  burst_st_e     state;
  logic [PW-1:0] occ, rd_idx;
  logic          check_q, accept, launch, more, step, finish, ctl_we;

  assign busy   = (state == ST_MOVE) || check_q;
  assign accept = host_wr && !busy && host_sel == H_DATA && host_start
                  && occ < PW'(DEPTH);
  assign launch = (state == ST_IDLE) && check_q && occ != '0
                  && (occ % PW'(BURST)) == '0
                  && chan_mode == MODE_RUN && dma_master;
  assign more   = (state == ST_MOVE) && rd_idx != occ && dma_cnt != '0;
  assign step   = more && wr_ready;
  assign finish = (state == ST_MOVE) && !more;

  assign wr_valid = more;
  assign wr_addr  = dma_dst;

  dreq_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(accept), .waddr(occ[IW-1:0]), .wdata(host_wdata[DW-1:0]),
    .raddr(rd_idx[IW-1:0]), .rdata(wr_data)
  );

  dreq_host_regs #(.LW(LW)) u_host (
    .clk(clk), .rst(rst), .we(host_wr && !busy), .sel(host_sel),
    .wdata(host_wdata), .step(step), .finish(finish),
    .start(host_start), .rv(host_rv), .len(host_len)
  );

  dreq_dma_chan #(.AW(AW), .CW(CW)) u_chan (
    .clk(clk), .rst(rst), .we(cfg_wr && !busy), .sel(cfg_sel),
    .wdata(cfg_wdata), .step(step), .set_end(finish && dma_cnt == '0),
    .ctl_we(ctl_we), .dst(dma_dst), .cnt(dma_cnt), .mode(chan_mode),
    .master(dma_master)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      occ       <= '0;
      rd_idx    <= '0;
      check_q   <= 1'b0;
      fifo_full <= 1'b0;
    end else begin
      check_q <= accept || ctl_we;
      if (launch) begin
        state  <= ST_MOVE;
        rd_idx <= '0;
      end else if (finish) begin
        state <= ST_IDLE;
      end else if (step) begin
        rd_idx <= rd_idx + 1'b1;
      end
      if (finish) begin
        occ       <= '0;
        fifo_full <= 1'b0;
      end else if (accept) begin
        occ <= occ + 1'b1;
        if (occ + 1'b1 == PW'(DEPTH)) fifo_full <= 1'b1;
      end
    end
  end

  a_r4_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= PW'(DEPTH));
  a_r8_drain_clear: assert property (@(posedge clk) disable iff (rst)
    finish |=> (occ == '0) && !fifo_full);
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  a_r13_busy_freeze: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish && !step) |=> $stable(host_len) && $stable(dma_dst));
endmodule

// File: tb/dreq_bridge_tb.sv
module dreq_bridge_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, cfg_wr = 0, wr_ready = 1;
  logic [1:0] host_sel = 0, cfg_sel = 0;
  logic [15:0] host_wdata = 0;
  logic [31:0] cfg_wdata = 0;
  logic busy, host_start, host_rv, fifo_full, dma_master, wr_valid;
  logic [15:0] host_len, wr_data;
  logic [31:0] dma_dst, wr_addr;
  logic [23:0] dma_cnt;
  logic [1:0] chan_mode;

  int checks = 0, fails = 0;
  bit rnd_ready = 0;
  bit done = 0;

  logic m_start, m_rv, m_full, m_master;
  logic [15:0] m_len;
  logic [31:0] m_dst;
  logic [23:0] m_cnt;
  logic [1:0] m_mode;
  int m_occ;
  logic [15:0] m_fifo [4];
  logic [47:0] exp_q [$];
  logic [47:0] got_q [$];

  always #5 clk = ~clk;

  dreq_bridge u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_ready(wr_ready), .busy(busy),
    .host_start(host_start), .host_rv(host_rv), .fifo_full(fifo_full),
    .host_len(host_len), .dma_dst(dma_dst), .dma_cnt(dma_cnt),
    .chan_mode(chan_mode), .dma_master(dma_master), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) if (wr_valid && wr_ready) got_q.push_back({wr_addr, wr_data});

  always @(negedge clk) wr_ready <= rnd_ready ? (($urandom % 4) != 0) : 1'b1;

  task automatic check(string tag, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "start", 48'(host_start), 48'(m_start));
    check(tag, "rv", 48'(host_rv), 48'(m_rv));
    check(tag, "full", 48'(fifo_full), 48'(m_full));
    check(tag, "len", 48'(host_len), 48'(m_len));
    check(tag, "dst", 48'(dma_dst), 48'(m_dst));
    check(tag, "cnt", 48'(dma_cnt), 48'(m_cnt));
    check(tag, "mode", 48'(chan_mode), 48'(m_mode));
    check(tag, "master", 48'(dma_master), 48'(m_master));
    check(tag, "words moved", 48'(got_q.size()), 48'(exp_q.size()));
    while (exp_q.size() > 0 && got_q.size() > 0)
      check(tag, "slave word", got_q.pop_front(), exp_q.pop_front());
    exp_q.delete();
    got_q.delete();
  endtask

  function automatic void model_burst();
    if (m_occ != 0 && (m_occ % 4) == 0 && m_mode == 2'b01 && m_master) begin
      for (int i = 0; i < m_occ && m_cnt != 0; i++) begin
        exp_q.push_back({m_dst, m_fifo[i]});
        m_dst = m_dst + 2;
        m_cnt = m_cnt - 1;
        if (m_len != 0) m_len = m_len - 1;
      end
      m_occ = 0;
      m_full = 0;
      if (m_len == 0) m_start = 0;
      if (m_cnt == 0) m_mode[1] = 1'b1;
    end
  endfunction

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_op(logic [1:0] sel, logic [15:0] d, string tag);
    @(negedge clk);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
    if (sel == 2'd0) begin m_start = d[0]; m_rv = d[1]; end
    else if (sel == 2'd1) m_len = {d[15:2], 2'b00};
    else if (sel == 2'd2 && m_start && m_occ < 4) begin
      m_fifo[m_occ] = d;
      m_occ++;
      if (m_occ == 4) m_full = 1;
      model_burst();
    end
    settle();
    compare_all(tag);
  endtask

  task automatic cfg_op(logic [1:0] sel, logic [31:0] d, string tag);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    case (sel)
      2'd0: m_dst = d;
      2'd1: m_cnt = d[23:0];
      2'd2: m_mode = d[1:0];
      default: m_master = d[0];
    endcase
    if (sel[1]) model_burst();
    settle();
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_start = 0; m_rv = 0; m_full = 0; m_master = 0;
    m_len = 0; m_dst = 0; m_cnt = 0; m_mode = 0; m_occ = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", "busy", 48'(busy), 48'd0);
    check("R1", "valid", 48'(wr_valid), 48'd0);
    compare_all("R1");
    // R2: low bits of length cleared
    host_op(2'd1, 16'h0017, "R2");
    // R11: count keeps 24 bits
    cfg_op(2'd1, 32'h1234_0010, "R11");
    cfg_op(2'd0, 32'h0600_0100, "R11");
    cfg_op(2'd3, 32'h1, "R5");
    // R3: FIFO writes without start are dropped
    for (int i = 0; i < 4; i++) host_op(2'd2, 16'h1000 + 16'(i), "R3");
    host_op(2'd0, 16'h0003, "R9");
    // R4 and R5: fill with mode off, no burst, overflow dropped
    for (int i = 0; i < 5; i++) host_op(2'd2, 16'hA000 + 16'(i), "R4");
    // R9: control write keeps full
    host_op(2'd0, 16'h0001, "R9");
    // R10: enabling mode drains buffered words; R6 and R8 via compare
    cfg_op(2'd2, 32'h1, "R10");
    // R5: next group of four bursts on the fourth write
    for (int i = 0; i < 4; i++) host_op(2'd2, 16'hB000 + 16'(i), "R6");
    // R13: length write during busy is dropped
    for (int i = 0; i < 3; i++) host_op(2'd2, 16'hC000 + 16'(i), "R13");
    @(negedge clk);
    host_wr = 1; host_sel = 2'd2; host_wdata = 16'hC003;
    @(negedge clk);
    host_sel = 2'd1; host_wdata = 16'h0FF0;
    m_fifo[3] = 16'hC003; m_occ = 4; m_full = 1; model_burst();
    @(negedge clk);
    host_wr = 0;
    settle();
    compare_all("R13");
    // R7: length runs out, start clears
    host_op(2'd1, 16'h0004, "R2");
    for (int i = 0; i < 4; i++) host_op(2'd2, 16'hD000 + 16'(i), "R7");
    // R7 and R8: count runs out mid-burst
    host_op(2'd0, 16'h0001, "R9");
    host_op(2'd1, 16'h0008, "R2");
    cfg_op(2'd1, 32'h2, "R11");
    for (int i = 0; i < 4; i++) host_op(2'd2, 16'hE000 + 16'(i), "R7");
    // R12: random stalls with random traffic
    rnd_ready = 1;
    cfg_op(2'd1, 32'h0000_0200, "R11");
    cfg_op(2'd2, 32'h1, "R10");
    host_op(2'd1, 16'h0100, "R2");
    for (int n = 0; n < 300; n++) begin
      int k = int'($urandom % 20);
      if (k < 11) host_op(2'd2, 16'($urandom), "R12");
      else if (k < 13) host_op(2'd0, (($urandom % 5) == 0) ? 16'h0002 : 16'h0001, "R9");
      else if (k < 14) host_op(2'd1, 16'($urandom % 64), "R2");
      else if (k < 16) cfg_op(2'd2, (($urandom % 3) == 0) ? 32'($urandom % 4) : 32'h1, "R5");
      else if (k < 17) cfg_op(2'd3, (($urandom % 4) == 0) ? 32'h0 : 32'h1, "R5");
      else if (k < 18) cfg_op(2'd0, $urandom, "R6");
      else cfg_op(2'd1, 32'($urandom % 24), "R7");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule